// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt lines onto a bank of sixteen inputs of a legacy interrupt controller. Each line owns a byte-wide route register. A value below 16 selects the controller input that the line drives. A value of 16 or more takes the line off every output. Software programs the route registers through a 32-bit configuration write port that carries a dword address, write data and byte enables. The four route bytes occupy the dword at byte offset 0x60, with line k in byte lane k.

The block keeps a registered level map with one bit for each pairing of controller input and line. On every clock the map is rebuilt from the live line levels under the routing that takes effect on that same edge. Each controller output is the OR of its group of bits in the map. Any level change or route change therefore shows at the outputs one clock later, and a route rewrite moves a line that is already asserted from its old input to its new one.

The block also has a combinational helper for bus enumeration. It maps a device slot number and an INTx pin to the shared line index that the board wiring assigns to that pin.

Top module: `pirq_router`

## Requirements
- R1: After reset every route register reads 0x80 on `route_o` and all sixteen `irq_o` bits are low.
- R2: A write with `cfg_we_i` high, `cfg_addr_i[7:2]` equal to 6'h18 and `cfg_be_i[k]` high loads `cfg_wdata_i[8k+7:8k]` into the route register of line k. The register reads back on `route_o[8k+7:8k]` exactly as written, bit 7 included, starting with the edge that performs the write.
- R3: A line whose route value is 16 or more drives no `irq_o` bit, whatever its level.
- R4: A line whose route value v is below 16 drives `irq_o[v]` with its level, delayed by one clock.
- R5: `irq_o[i]` is the OR of the registered levels of all lines routed to input i, so two lines that share an input keep it high while either of them is high.
- R6: A route write rebuilds the level map from the current line levels. On the clock after the write, a high line drops from its old input and appears on its new one.
- R7: A write to any other dword address, or a write whose byte enable for lane k is low, leaves route register k unchanged. Route registers do not change while `cfg_we_i` is low.
- R8: `slot_pirq_o` equals (`intx_i` + `slot_i` - 1) mod 4, with `intx_i` 0 to 3 standing for INTA to INTD, and it is combinational.
- R9: When a route write and a change of line levels fall on the same edge, the outputs on the next clock reflect both the new routing and the new levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address; bits 7:2 select the dword |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_be_i | input | 4 | Byte enables for the write data |
| pirq_i | input | 4 | Levels of the shared interrupt lines, index 0 to 3 |
| route_o | output | 32 | Route register readback, line k in bits 8k+7:8k |
| irq_o | output | 16 | Registered levels toward the interrupt controller inputs |
| slot_i | input | 5 | Device slot number for the pin lookup |
| intx_i | input | 2 | Device INTx pin, 0 to 3 for A to D |
| slot_pirq_o | output | 2 | Shared line index used by that slot and pin |

## Verification
Two functions can land on one clock edge: a route register rewrite and a change of line levels. The bench provokes this by changing `pirq_i` together with a write on most cycles of a long randomized run. It mixes in-range routes, out-of-range routes, values with bit 7 set, partial byte enables and wrong addresses. After each edge the bench compares `irq_o` with an expected vector computed from its own copy of the routes and the levels sampled at that edge. A design that rebuilds the map from stale routes, or that drops a level change made in the same cycle as a write, therefore shows a mismatch on the following clock.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int ROUTE_W = 8;
  localparam int CFG_DW  = 32;
  localparam int CFG_BE  = CFG_DW / 8;
  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ    = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  parameter int RESET_VAL = 'h80
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [CFG_DW-1:0]         wdata_i,
  input  logic [CFG_BE-1:0]         be_i,
  output logic [N_PIRQ*ROUTE_W-1:0] route_q_o,
  output logic [N_PIRQ*ROUTE_W-1:0] route_d_o
);
  localparam int DW_W = ADDR_W - 2;

  for (genvar r = 0; r < N_PIRQ; r++) begin : g_reg
    localparam int OFF  = BASE_ADDR + r;
    localparam int LANE = OFF % CFG_BE;
    localparam int DWI  = OFF / CFG_BE;
    logic   hit;
    route_t q;

    assign hit = we_i && (addr_i[ADDR_W-1:2] == DW_W'(DWI)) && be_i[LANE];
    assign route_d_o[r*ROUTE_W +: ROUTE_W] = hit ? wdata_i[LANE*8 +: ROUTE_W] : q;
    assign route_q_o[r*ROUTE_W +: ROUTE_W] = q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= route_t'(RESET_VAL);
      else         q <= route_d_o[r*ROUTE_W +: ROUTE_W];
    end
  end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ = 4,
  parameter int N_IRQ  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PIRQ*ROUTE_W-1:0] route_d_i,
  input  logic [N_PIRQ-1:0]         pirq_i,
  output logic [N_IRQ-1:0]          irq_o
);
  localparam int MAP_W = N_IRQ * N_PIRQ;

  logic [MAP_W-1:0] map_d, map_q;

  // Map rebuilt every cycle from live levels under the routing of this edge
  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    for (genvar r = 0; r < N_PIRQ; r++) begin : g_pirq
      assign map_d[i*N_PIRQ + r] =
        pirq_i[r] && (route_d_i[r*ROUTE_W +: ROUTE_W] == ROUTE_W'(i));
    end
    assign irq_o[i] = |map_q[i*N_PIRQ +: N_PIRQ];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_d;
  end
endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
  parameter int N_PIRQ = 4,
  parameter int SLOT_W = 5
) (
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic [$clog2(N_PIRQ)-1:0] intx_i,
  output logic [$clog2(N_PIRQ)-1:0] pirq_o
);
  localparam int PW  = $clog2(N_PIRQ);
  localparam int SW  = SLOT_W + 2;
  logic [SW-1:0] sum;

  // slot - 1 taken modulo N_PIRQ as slot + N_PIRQ - 1
  assign sum    = SW'(slot_i) + SW'(intx_i) + SW'(N_PIRQ - 1);
  assign pirq_o = sum[PW-1:0];
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ    = 4,
  parameter int N_IRQ     = 16,
  parameter int ADDR_W    = 8,
  parameter int SLOT_W    = 5,
  parameter int BASE_ADDR = 'h60
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [ADDR_W-1:0]         cfg_addr_i,
  input  logic [CFG_DW-1:0]         cfg_wdata_i,
  input  logic [CFG_BE-1:0]         cfg_be_i,
  input  logic [N_PIRQ-1:0]         pirq_i,
  output logic [N_PIRQ*ROUTE_W-1:0] route_o,
  output logic [N_IRQ-1:0]          irq_o,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic [$clog2(N_PIRQ)-1:0] intx_i,
  output logic [$clog2(N_PIRQ)-1:0] slot_pirq_o
);
  logic [N_PIRQ*ROUTE_W-1:0] route_d;

  pirq_route_regs #(
    .N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .RESET_VAL('h80)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .be_i(cfg_be_i),
    .route_q_o(route_o), .route_d_o(route_d)
  );

  pirq_level_map #(.N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ)) u_map (
    .clk_i, .rst_ni, .route_d_i(route_d), .pirq_i, .irq_o
  );

  pirq_slot_swizzle #(.N_PIRQ(N_PIRQ), .SLOT_W(SLOT_W)) u_swz (
    .slot_i, .intx_i, .pirq_o(slot_pirq_o)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ = 4,
  parameter int N_IRQ  = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cfg_we_i,
  input logic [N_PIRQ-1:0]         pirq_i,
  input logic [N_PIRQ*ROUTE_W-1:0] route_o,
  input logic [N_IRQ-1:0]          irq_o
);
  logic [N_PIRQ-1:0] lvl_q;
  logic [N_IRQ-1:0]  hit_v;
  logic              all_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= pirq_i;
  end

  always_comb begin
    hit_v   = '0;
    all_off = 1'b1;
    for (int r = 0; r < N_PIRQ; r++) begin
      if (route_o[r*ROUTE_W +: ROUTE_W] < ROUTE_W'(N_IRQ)) begin
        all_off = 1'b0;
        if (lvl_q[r]) hit_v[route_o[r*ROUTE_W +: 4]] = 1'b1;
      end
    end
  end

  assert_disabled_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off |-> (irq_o == '0));

  assert_no_stray_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ((irq_o & ~hit_v) == '0));

  assert_or_covers_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_v != '0) |-> ((hit_v & ~irq_o) == '0));

  assert_route_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(route_o));
endmodule

bind pirq_router pirq_router_chk #(.N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
  .pirq_i(pirq_i), .route_o(route_o), .irq_o(irq_o)
);

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [3:0]  pirq = '0;
  logic [31:0] route;
  logic [15:0] irq;
  logic [4:0]  slot = '0;
  logic [1:0]  intx = '0;
  logic [1:0]  spirq;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] m_route [4];
  logic [3:0] m_lvl;

  always #5 clk = ~clk;

  pirq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_be_i(be), .pirq_i(pirq), .route_o(route),
    .irq_o(irq), .slot_i(slot), .intx_i(intx), .slot_pirq_o(spirq)
  );

  function automatic logic [15:0] exp_irq();
    logic [15:0] e = '0;
    for (int r = 0; r < 4; r++)
      if (m_route[r] < 8'd16 && m_lvl[r]) e[m_route[r][3:0]] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] exp_route();
    return {m_route[3], m_route[2], m_route[1], m_route[0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One edge: model follows the held inputs, then outputs are compared
  task automatic step(string tag);
    @(posedge clk);
    if (we && addr[7:2] == 6'h18)
      for (int k = 0; k < 4; k++) if (be[k]) m_route[k] = wdata[8*k +: 8];
    m_lvl = pirq;
    #1;
    check({tag, " irq"}, {16'h0, irq}, {16'h0, exp_irq()});
    check({tag, " route"}, route, exp_route());
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] b, string tag);
    we = 1'b1; addr = a; wdata = d; be = b;
    step(tag);
    we = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) m_route[r] = 8'h80;
    m_lvl = '0;
    #23;
    // R1: reset values
    check("R1 route", route, 32'h80808080);
    check("R1 irq", {16'h0, irq}, 32'h0);
    rst_n = 1'b1;
    pirq = 4'hF;
    step("R3 all lines disabled after reset");

    // R2/R4: each line to each input, and out of range values
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 20; v++) begin
        wr(8'h60, 32'(v) << (8 * r), 4'(1 << r), "R2 single lane write");
        pirq = 4'(1 << r);
        step(v < 16 ? "R4 steer" : "R3 disabled");
        pirq = '0;
        step("R4 level low");
        wr(8'h60, 32'h80 << (8 * r), 4'(1 << r), "R2 bit7 readback");
      end

    // R5: two lines sharing one input
    wr(8'h60, 32'h80800707, 4'hF, "R2 full write");
    pirq = 4'b0011; step("R5 both high");
    pirq = 4'b0010; step("R5 one high");
    pirq = 4'b0000; step("R5 none high");

    // R6: reroute an asserted line
    pirq = 4'b0001; step("R6 line high");
    wr(8'h60, 32'h8080070C, 4'b0001, "R6 reroute 7 to 12");
    step("R6 after reroute");

    // R7: wrong address, missing byte enables
    wr(8'h64, 32'h01010101, 4'hF, "R7 wrong dword");
    wr(8'h5C, 32'h02020202, 4'hF, "R7 wrong dword below");
    wr(8'h60, 32'h03030303, 4'b0000, "R7 no byte enable");
    wr(8'h61, 32'h04040404, 4'b0100, "R7 partial enable");

    // R9: random writes with simultaneous level changes
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d = $urandom;
      int sel = $urandom_range(0, 7);
      for (int k = 0; k < 4; k++) if (d[8*k+5]) d[8*k +: 8] = {3'b0, d[8*k +: 5]};
      pirq = 4'($urandom);
      we = (sel < 6);
      addr = (sel == 5) ? 8'h68 : 8'h60;
      wdata = d;
      be = 4'($urandom);
      step("R9 write and level change");
      we = 1'b0;
    end

    // R8: full slot and pin sweep
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        slot = 5'(s); intx = 2'(p);
        #1;
        check("R8 swizzle", {30'h0, spirq}, 32'((p + s + 3) % 4));
      end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule